// File: doc/BRIEF.md
# Eight-Channel SPI ADC Host Controller

This block sits between a byte-wide register bus and a 12-bit, eight-channel serial analog-to-digital converter. Software loads a command byte that selects a channel and an input range. The write launches a 16-bit SPI frame that carries the command out and brings back the result the converter holds. A separate control register issues a conversion. The block produces a one-cycle start strobe toward the converter and reports busy until the converter's busy line has gone low again.

Results are pipelined. The frame that delivers a command also returns the conversion made for the command before it, so software reads a channel's value one command later. Each command owes the converter one conversion. Until that conversion is issued, further command writes are refused and a sticky error flag is raised.

Top module: `adc_host_ctrl`

## Requirements
- R1: The command byte is sent MSB first in the upper byte of a 16-bit frame, and the lower byte is zero. The byte places channel bit 0 at bit 6, channel bits 2:1 at bits 5:4 and the range code (0 = ±5 V, 1 = ±10 V, 2 = 0..+5 V, 3 = 0..+10 V) at bits 3:2, so channel 3 with range 2 is 0x58.
- R2: The SPI link uses mode 0. sclk idles low and mosi changes only while sclk is low. cs_n stays low for 16 sclk periods of 2*CLK_DIV system clocks each, which is exactly 32*CLK_DIV clocks.
- R3: A write to the command register (address 1) that is accepted starts exactly one frame. Status bit 0 (address 2) reads 1 from the cycle after the write until the frame ends.
- R4: Writing 1 to control bit 0 (address 3) produces exactly one conv_start pulse, one clock wide. Control bit 2 reads 1 from that point until the synchronized converter busy input has fallen.
- R5: The 12 bits captured in the most recent frame (bits 15:4 of the frame) read back in two places. Address 1 returns bits 11:4. Address 0 returns bits 3:0 in its bits 7:4, and its bits 3:0 read zero. The value returned belongs to the conversion made before the last command.
- R6: A command write is ignored and status bit 1 (sticky error) is set when a conversion is still owed for an earlier command or when a frame is in progress. Writing 1 to status bit 1 clears the flag.
- R7: A conversion request is ignored while the converter is busy or while a frame is in progress.
- R8: Busy bits are read-only. Writes to address 0 and to unused bits have no effect, and unused bits read zero.
- R9: After reset, cs_n is 1, sclk is 0 and conv_start is 0, and all four registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| sclk | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to converter |
| miso | input | 1 | SPI data from converter |
| conv_start | output | 1 | One-cycle conversion start strobe |
| adc_busy_in | input | 1 | Converter busy, asynchronous |

## Verification
The assertions check the following on every cycle:
- conv_start is only a single-cycle pulse.
- sclk stays low while the link is idle, and mosi holds steady while sclk is high.
- No conversion is started during a frame.
- The busy flag is raised together with the start pulse.
- The error flag persists until it is cleared.

Only the bench scenarios can show the rest: the byte encoding on the wire, the frame length, the one-command lag of returned results, and that refused commands and conversion requests truly produce no frame or pulse. The bench shows these through a serial converter model that returns a known value for each command.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam logic [1:0] REG_RES_LO = 2'd0;
  localparam logic [1:0] REG_CMD    = 2'd1;
  localparam logic [1:0] REG_STAT   = 2'd2;
  localparam logic [1:0] REG_CTRL   = 2'd3;
  localparam int STAT_SPI_BUSY = 0;
  localparam int STAT_ERR      = 1;
  localparam int CTRL_START    = 0;
  localparam int CTRL_BUSY     = 2;
endpackage

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         miso,
  output logic         sclk,
  output logic         cs_n,
  output logic         mosi,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int DW = $clog2(DIV + 1);
  localparam int BW = $clog2(W);

  logic [DW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [W-1:0]  tx_q, rx_q;
  logic          act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0; sclk <= 1'b0; cs_n <= 1'b1; done <= 1'b0;
      div_q <= '0;   bit_q <= '0;  tx_q <= '0;   rx_q <= '0;
    end else begin
      done <= 1'b0;
      if (!act_q) begin
        if (start) begin
          act_q <= 1'b1; cs_n <= 1'b0; sclk <= 1'b0;
          tx_q  <= tx_word; div_q <= '0; bit_q <= '0;
        end
      end else if (div_q == DW'(DIV - 1)) begin
        div_q <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx_q <= {rx_q[W-2:0], miso};
        end else begin
          sclk <= 1'b0;
          tx_q <= {tx_q[W-2:0], 1'b0};
          if (bit_q == BW'(W - 1)) begin
            act_q <= 1'b0; cs_n <= 1'b1; done <= 1'b1;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign mosi    = tx_q[W-1];
  assign busy    = act_q;
  assign rx_word = rx_q;
endmodule

// File: rtl/adc_busy_track.sv
module adc_busy_track #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic busy_in,
  output logic busy_out
);
  logic [STAGES-1:0] sync_q;
  logic              pend_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk)
          if (rst) sync_q[0] <= 1'b0; else sync_q[0] <= busy_in;
      end else begin : g_next
        always_ff @(posedge clk)
          if (rst) sync_q[s] <= 1'b0; else sync_q[s] <= sync_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                     pend_q <= 1'b0;
    else if (start)              pend_q <= 1'b1;
    else if (sync_q[STAGES-1])   pend_q <= 1'b0;
  end

  assign busy_out = pend_q | sync_q[STAGES-1];
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int FRAME_W     = 16,
  parameter int CMD_W       = 8,
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso,
  output logic       conv_start,
  input  logic       adc_busy_in
);
  localparam int LO_W  = RES_W - 8;
  localparam int PAD_W = FRAME_W - CMD_W;

  logic               spi_busy, spi_done, adc_busy_flag;
  logic [FRAME_W-1:0] rx_word;
  logic [RES_W-1:0]   res_q;
  logic               owed_q, err_q;
  logic               cmd_wr, cmd_acc, conv_acc, err_clr;

  assign cmd_wr   = bus_we && bus_addr == REG_CMD;
  assign cmd_acc  = cmd_wr && !spi_busy && !owed_q;
  assign conv_acc = bus_we && bus_addr == REG_CTRL && bus_wdata[CTRL_START]
                    && !spi_busy && !adc_busy_flag;
  assign err_clr  = bus_we && bus_addr == REG_STAT && bus_wdata[STAT_ERR];

  spi_frame_engine #(.W(FRAME_W), .DIV(CLK_DIV)) u_spi (
    .clk(clk), .rst(rst), .start(cmd_acc),
    .tx_word({bus_wdata[CMD_W-1:0], {PAD_W{1'b0}}}),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .busy(spi_busy), .done(spi_done), .rx_word(rx_word)
  );

  adc_busy_track #(.STAGES(SYNC_STAGES)) u_busy (
    .clk(clk), .rst(rst), .start(conv_acc),
    .busy_in(adc_busy_in), .busy_out(adc_busy_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q <= 1'b0; err_q <= 1'b0; conv_start <= 1'b0; res_q <= '0;
    end else begin
      conv_start <= conv_acc;
      if (cmd_acc)       owed_q <= 1'b1;
      else if (conv_acc) owed_q <= 1'b0;
      if (cmd_wr && !cmd_acc) err_q <= 1'b1;
      else if (err_clr)       err_q <= 1'b0;
      if (spi_done) res_q <= rx_word[FRAME_W-1 -: RES_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (bus_addr)
        REG_RES_LO: bus_rdata <= {res_q[LO_W-1:0], {(8-LO_W){1'b0}}};
        REG_CMD:    bus_rdata <= res_q[RES_W-1 -: 8];
        REG_STAT:   bus_rdata <= {6'b0, err_q, spi_busy};
        default:    bus_rdata <= {5'b0, adc_busy_flag, 2'b0};
      endcase
    end
  end
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk
  import adc_host_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bus_we,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       sclk,
  input logic       cs_n,
  input logic       mosi,
  input logic       conv_start,
  input logic       busy_flag,
  input logic       err_flag
);
  // R4
  conv_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  // R7
  no_conv_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> cs_n);
  // R4
  busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy_flag);
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !(bus_we && bus_addr == REG_STAT && bus_wdata[STAT_ERR]))
      |=> err_flag);
endmodule

bind adc_host_ctrl adc_host_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
  .conv_start(conv_start), .busy_flag(adc_busy_flag), .err_flag(err_q)
);

// File: tb/sim_adc_host_ctrl.sv
module sim_adc_host_ctrl;
  localparam int DIV  = 4;
  localparam int CONV = 50;

  logic clk = 0, rst = 1, bus_we = 0, miso, cbusy = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic sclk, cs_n, mosi, conv_start;

  adc_host_ctrl #(.CLK_DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso), .conv_start(conv_start), .adc_busy_in(cbusy)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int frames = 0, rises = 0, lowcnt = 0, pulses = 0, ccnt = 0;
  logic [15:0] sl_rx = 0, sl_tx = 0, last_rx = 0;
  logic [7:0]  last_cmd = 0;
  logic [11:0] conv_data = 0;

  function automatic logic [11:0] samp(input logic [7:0] c);
    return {c, 4'h0} ^ 12'h5A3;
  endfunction
  function automatic logic [7:0] enc(input logic [2:0] ch, input logic [1:0] rg);
    return {1'b0, ch[0], ch[2:1], rg, 2'b00};
  endfunction

  // serial converter model
  assign miso = sl_tx[15];
  always @(negedge cs_n) begin sl_tx = {conv_data, 4'h0}; rises = 0; lowcnt = 0; end
  always @(posedge cs_n) begin last_rx = sl_rx; last_cmd = sl_rx[15:8]; frames++; end
  always @(posedge sclk) if (!cs_n) begin sl_rx = {sl_rx[14:0], mosi}; rises++; end
  always @(negedge sclk) if (!cs_n) sl_tx = {sl_tx[14:0], 1'b0};
  always @(negedge clk) if (!cs_n) lowcnt++;
  always @(posedge clk) begin
    if (conv_start) begin pulses++; cbusy <= 1; ccnt <= CONV; end
    else if (ccnt > 0) begin
      ccnt <= ccnt - 1;
      if (ccnt == 1) begin cbusy <= 0; conv_data <= samp(last_cmd); end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = bus_rdata;
  endtask
  task automatic wait_bit(input logic [1:0] a, input int b);
    logic [7:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(a, v);
      if (!v[b]) break;
    end
  endtask

  // channel, range, expected wire byte
  localparam logic [12:0] VEC [4] = '{
    {3'd3, 2'd2, 8'h58}, {3'd0, 2'd0, 8'h00},
    {3'd7, 2'd3, 8'h7C}, {3'd4, 2'd1, 8'h24}
  };

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, cmd;
    logic [11:0] prev;
    int f0, p0;
    repeat (4) @(negedge clk);
    rst = 0;
    // R9 reset state
    check("R9 cs_n", cs_n, 1);
    check("R9 sclk", sclk, 0);
    check("R9 conv_start", conv_start, 0);
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R9 reg", v, 0); end

    prev = 0;
    for (int i = 0; i < 4; i++) begin
      cmd = enc(VEC[i][12:10], VEC[i][9:8]);
      f0 = frames;
      wr(2'd1, cmd);
      rd(2'd2, v); check("R3 spi busy", v, 8'h01);
      wait_bit(2'd2, 0);
      check("R3 one frame", frames, f0 + 1);
      check("R1 cmd byte", last_rx[15:8], VEC[i][7:0]);
      check("R1 low byte", last_rx[7:0], 0);
      check("R2 sclk count", rises, 16);
      check("R2 cs_n low", lowcnt, 32 * DIV);
      rd(2'd1, v); check("R5 hi", v, prev[11:4]);
      rd(2'd0, v); check("R5 lo", v, {prev[3:0], 4'h0});
      p0 = pulses;
      wr(2'd3, 8'h01);
      @(negedge clk);
      check("R4 pulse", pulses, p0 + 1);
      rd(2'd3, v); check("R4 busy", v, 8'h04);
      wr(2'd3, 8'h01);
      wait_bit(2'd3, 2);
      check("R7 ignored while busy", pulses, p0 + 1);
      rd(2'd3, v); check("R4 done", v, 0);
      prev = samp(cmd);
    end

    // R6 command while a conversion is owed
    wr(2'd1, enc(3'd1, 2'd0));
    wait_bit(2'd2, 0);
    f0 = frames;
    wr(2'd1, 8'h7C);
    repeat (10) @(negedge clk);
    check("R6 no frame", frames, f0);
    rd(2'd2, v); check("R6 err set", v, 8'h02);
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R6 err clr", v, 0);
    rd(2'd1, v); check("R5 lag", v, prev[11:4]);
    p0 = pulses;
    wr(2'd3, 8'h01); wait_bit(2'd3, 2);
    check("R4 owed conv", pulses, p0 + 1);

    // R7 conversion request during a frame
    wr(2'd1, enc(3'd2, 2'd3));
    p0 = pulses;
    wr(2'd3, 8'h01);
    wait_bit(2'd2, 0);
    check("R7 ignored in frame", pulses, p0);
    wr(2'd3, 8'h01); wait_bit(2'd3, 2);
    check("R7 after frame", pulses, p0 + 1);

    // R8 read-only and unused bits
    p0 = pulses;
    wr(2'd3, 8'hFE);
    repeat (3) @(negedge clk);
    check("R8 no conv", pulses, p0);
    rd(2'd3, v); check("R8 ctrl", v, 0);
    prev = samp(enc(3'd1, 2'd0));
    wr(2'd0, 8'hFF);
    rd(2'd0, v); check("R8 lo unchanged", v, {prev[3:0], 4'h0});
    wr(2'd2, 8'hFD);
    rd(2'd2, v); check("R8 stat", v, 0);
    check("R8 no frame", cs_n, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule